// File: doc/BRIEF.md
# Paged Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock and open-drain data). It gives an external host access to a 256-byte window. Bytes 0 to 127 form a single lower page that is always visible. Bytes 128 to 255 are an upper window. The page number held in byte 127 chooses which bank of storage appears in that upper window. Logic inside the chip reaches the same storage through a 16-bit word port with byte enables. That port is how it publishes monitor values and picks up settings written by the host.

An active-low select input gates all bus activity. While it is high, the slave acknowledges nothing and never pulls the data line. Some lower-page bytes are two-byte monitor fields, high byte first. When the host reads such a high byte, the block captures the matching low byte at the same instant. If the host reads that low byte next in the same transfer, it gets the captured copy, so a host that reads both bytes in one pass sees a consistent pair.

Top module: `twi_paged_slave`

## Requirements
- R1: The slave acknowledges only the address bytes A0h (write) and A1h (read). After any other address byte it sends no ACK and leaves SDA released until the next START.
- R2: While `sel_n` is high, the slave acknowledges no byte and does not drive SDA.
- R3: In a write transfer, the byte after the address byte sets the byte pointer. A repeated START followed by A1h then returns data starting at that pointer. A STOP ends the transfer.
- R4: The byte pointer advances by one after each data byte. In the lower page it wraps from 127 to 0. In the upper window it wraps from 255 to 128.
- R5: Byte 127 is the page register, and it reads back what was last written to it. With page 0 the upper window maps to bank 1, and with page 3 it maps to bank 2. On the word port, the word index is bank*64 + (byte address mod 128)/2. The even byte is bits 15:8 of the word.
- R6: While the page register holds a value other than 0 or 3, reads of bytes 128 to 255 return 00h and writes to them change no storage.
- R7: Bytes 22 to 81 hold monitor fields. A read of an even byte in that range captures the odd byte that follows it. If the next byte read in the same transfer is that odd byte, it returns the captured value even if the word port has rewritten it in between.
- R8: When the master answers a read byte with NACK, the slave releases SDA and stays silent through any further clocks until START or STOP.
- R9: The word port writes the bytes selected by `int_be` (bit 1 for the high byte). `int_rdata` shows the word at `int_addr` one clock later.
- R10: After reset, SDA is released and the page register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select; high silences the slave |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull data line low when 1 (open drain) |
| int_we | input | 1 | Word port write strobe |
| int_be | input | 2 | Word port byte enables (1 = high byte) |
| int_addr | input | 8 | Word port word index |
| int_wdata | input | 16 | Word port write data |
| int_rdata | output | 16 | Word port read data, one clock after address |

## Verification
Bus inputs pass two synchronizer flops and an edge register, and the data-line driver is itself a flop. The slave's response to an SCL falling edge therefore appears about four clocks after that edge. The bench holds each quarter of a bus bit for ten clocks and samples SDA in the middle of the SCL high time, well after any change has settled. Read data for a byte is fetched at the SCL rise of the preceding acknowledge slot and shifted out from the following fall. The coherence check therefore rewrites a monitor word while SCL is low and before that acknowledge rise. Word-port reads are sampled two clocks after the address is set: one clock of storage latency plus margin.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_WR, ST_RD, ST_HOLD
  } bus_state_e;

  typedef enum logic [1:0] {
    RK_MEM, RK_PAGE, RK_ZERO, RK_SHADOW
  } rd_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_link.sv
module twi_link
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_byte,
  output logic              sda_oe,
  output logic              bus_re,
  output logic              bus_we,
  output logic              txn_clr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata
);
  bus_state_e state;
  logic [3:0] bitcnt;
  logic       in_ack, rw, nack_q;
  logic [7:0] sh, tx;
  logic [ADDR_W-1:0] ptr_next;

  assign ptr_next = {bus_addr[ADDR_W-1], bus_addr[ADDR_W-2:0] + 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0; rw <= 1'b0; nack_q <= 1'b0;
      sh <= '0; tx <= '0; sda_oe <= 1'b0; bus_re <= 1'b0; bus_we <= 1'b0;
      txn_clr <= 1'b0; bus_addr <= '0; bus_wdata <= '0;
    end else begin
      bus_re <= 1'b0; bus_we <= 1'b0; txn_clr <= 1'b0;
      if (sel_n) begin
        state <= ST_IDLE; sda_oe <= 1'b0; in_ack <= 1'b0;
      end else if (start_det) begin
        state <= ST_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0; txn_clr <= 1'b1;
      end else if (stop_det) begin
        state <= ST_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0; txn_clr <= 1'b1;
      end else if (state == ST_IDLE || state == ST_HOLD) begin
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (!in_ack) begin
          sh     <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else begin
          if (state == ST_RD) nack_q <= sda_s;
          if (state == ST_RD || (state == ST_DEV && rw)) bus_re <= 1'b1;
        end
      end else if (scl_fall) begin
        if (!in_ack && bitcnt == 4'd8) begin
          in_ack <= 1'b1;
          case (state)
            ST_DEV: if (sh[7:1] == DEV_ADDR) begin
                      sda_oe <= 1'b1; rw <= sh[0];
                    end else state <= ST_IDLE;
            ST_REG: begin bus_addr <= sh[ADDR_W-1:0]; sda_oe <= 1'b1; end
            ST_WR:  begin bus_we <= 1'b1; bus_wdata <= sh; sda_oe <= 1'b1; end
            default: sda_oe <= 1'b0;
          endcase
        end else if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (state)
            ST_DEV, ST_RD: begin
              if ((state == ST_DEV && !rw) ) state <= ST_REG;
              else if (state == ST_RD && nack_q) state <= ST_HOLD;
              else begin
                state    <= ST_RD;
                tx       <= rd_byte;
                sda_oe   <= ~rd_byte[7];
                bus_addr <= ptr_next;
              end
            end
            ST_REG:  state <= ST_WR;
            ST_WR:   bus_addr <= ptr_next;
            default: state <= ST_IDLE;
          endcase
        end else if (state == ST_RD) begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
  end

  AST_SEL_SILENT: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !sda_oe); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R1
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> !sda_oe); // R8
  AST_PTR_HALF: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && in_ack && state == ST_WR && !sel_n && !start_det && !stop_det)
      |=> bus_addr[ADDR_W-1] == $past(bus_addr[ADDR_W-1])); // R4
  AST_NO_RW_MIX: assert property (@(posedge clk) disable iff (rst)
    !(bus_re && bus_we)); // R3
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
  import twi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_ALT  = 3,
  parameter int MON_FIRST = 22,
  parameter int MON_LAST  = 81
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_clr,
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_byte,
  input  logic              int_we,
  input  logic [1:0]        int_be,
  input  logic [ADDR_W-1:0] int_addr,
  input  logic [15:0]       int_wdata,
  output logic [15:0]       int_rdata
);
  localparam int WORDS = 2 ** (ADDR_W - 2);
  localparam int DEPTH = 3 * WORDS;
  localparam logic [ADDR_W-1:0] PAGE_ADDR = {1'b0, {(ADDR_W-1){1'b1}}};

  logic [7:0] mem_hi [DEPTH];
  logic [7:0] mem_lo [DEPTH];
  logic [7:0] page_q, rd_hi_q, rd_lo_q, shadow_q;
  logic [ADDR_W-1:0] shadow_addr, addr_q, widx;
  logic [1:0] bank;
  logic bank_ok, is_page, mon_hi, shadow_v, pend_q, lane_q, mem_we;
  rd_kind_e kind_q;

  always_comb begin
    bank = 2'd0; bank_ok = 1'b1;
    if (bus_addr[ADDR_W-1]) begin
      if (page_q == 8'd0) bank = 2'd1;
      else if (page_q == 8'(PAGE_ALT)) bank = 2'd2;
      else bank_ok = 1'b0;
    end
  end

  assign widx    = {bank, bus_addr[ADDR_W-2:1]};
  assign is_page = (bus_addr == PAGE_ADDR);
  assign mon_hi  = !bus_addr[ADDR_W-1] && !bus_addr[0] &&
                   (int'(bus_addr) >= MON_FIRST) && (int'(bus_addr) < MON_LAST);
  assign mem_we  = bus_we && bank_ok && !is_page;

  always_ff @(posedge clk) begin
    if (mem_we && !bus_addr[0]) mem_hi[widx] <= bus_wdata;
    if (mem_we &&  bus_addr[0]) mem_lo[widx] <= bus_wdata;
    if (int_we && int_be[1]) mem_hi[int_addr] <= int_wdata[15:8];
    if (int_we && int_be[0]) mem_lo[int_addr] <= int_wdata[7:0];
    if (bus_re) begin
      rd_hi_q <= mem_hi[widx];
      rd_lo_q <= mem_lo[widx];
    end
    int_rdata <= {mem_hi[int_addr], mem_lo[int_addr]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0; shadow_v <= 1'b0; shadow_q <= '0; shadow_addr <= '0;
      pend_q <= 1'b0; lane_q <= 1'b0; addr_q <= '0; kind_q <= RK_ZERO;
    end else begin
      pend_q <= 1'b0;
      if (bus_we && is_page) page_q <= bus_wdata;
      if (bus_re) begin
        addr_q <= bus_addr;
        lane_q <= bus_addr[0];
        pend_q <= mon_hi && bank_ok;
        if (is_page) kind_q <= RK_PAGE;
        else if (!bank_ok) kind_q <= RK_ZERO;
        else if (shadow_v && bus_addr == shadow_addr) kind_q <= RK_SHADOW;
        else kind_q <= RK_MEM;
      end
      if (pend_q) begin
        shadow_v    <= 1'b1;
        shadow_q    <= rd_lo_q;
        shadow_addr <= addr_q + 1'b1;
      end else if (bus_re || bus_we || txn_clr) begin
        shadow_v <= 1'b0;
      end
    end
  end

  always_comb begin
    case (kind_q)
      RK_PAGE:   rd_byte = page_q;
      RK_ZERO:   rd_byte = 8'h00;
      RK_SHADOW: rd_byte = shadow_q;
      default:   rd_byte = lane_q ? rd_lo_q : rd_hi_q;
    endcase
  end

  AST_PAGE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && is_page) |=> $stable(page_q)); // R5
  AST_SHADOW_ODD: assert property (@(posedge clk) disable iff (rst)
    shadow_v |-> shadow_addr[0]); // R7
endmodule

// File: rtl/twi_paged_slave.sv
module twi_paged_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         ADDR_W    = 8,
  parameter int         SYNC_N    = 2,
  parameter int         PAGE_ALT  = 3,
  parameter int         MON_FIRST = 22,
  parameter int         MON_LAST  = 81
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              int_we,
  input  logic [1:0]        int_be,
  input  logic [ADDR_W-1:0] int_addr,
  input  logic [15:0]       int_wdata,
  output logic [15:0]       int_rdata
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic bus_re, bus_we, txn_clr;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_wdata, rd_byte;

  twi_line_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_link #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_link (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .bus_re(bus_re), .bus_we(bus_we), .txn_clr(txn_clr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  twi_regbank #(.ADDR_W(ADDR_W), .PAGE_ALT(PAGE_ALT),
                .MON_FIRST(MON_FIRST), .MON_LAST(MON_LAST)) u_bank (
    .clk(clk), .rst(rst), .txn_clr(txn_clr), .bus_re(bus_re), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_byte(rd_byte),
    .int_we(int_we), .int_be(int_be), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata)
  );
endmodule

// File: tb/test_twi_paged_slave.sv
module test_twi_paged_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic int_we = 1'b0;
  logic [1:0] int_be = 2'b00;
  logic [7:0] int_addr = '0;
  logic [15:0] int_wdata = '0;
  logic [15:0] int_rdata;
  logic drv_seen = 1'b0;
  logic drv_clr = 1'b0;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  always @(posedge clk) begin
    if (drv_clr) drv_seen <= 1'b0;
    else if (sda_oe) drv_seen <= 1'b1;
  end

  twi_paged_slave i_twi_paged_slave (
    .clk(clk), .rst(rst), .sel_n(sel_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .int_we(int_we), .int_be(int_be), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_drv();
    drv_clr = 1'b1; wclk(1); drv_clr = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(Q); scl_m = 1'b1; wclk(2 * Q); scl_m = 1'b0; wclk(Q);
    end
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    acked = (sda_line == 1'b0);
    wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic recv_bits(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(Q); scl_m = 1'b1; wclk(Q); b[i] = sda_line; wclk(Q); scl_m = 1'b0;
    end
    wclk(Q);
  endtask

  task automatic send_ack(input logic nack);
    sda_m = nack; wclk(Q); scl_m = 1'b1; wclk(2 * Q); scl_m = 1'b0; wclk(Q);
    sda_m = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d [4], input int n);
    logic ak;
    bus_start(); send_byte(8'hA0, ak); send_byte(a, ak);
    for (int k = 0; k < n; k++) send_byte(d[k], ak);
    bus_stop();
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] d [4];
    d = '{v, 8'h00, 8'h00, 8'h00};
    bus_write(a, d, 1);
  endtask

  task automatic bus_read(input logic [7:0] a, input int n, output logic [7:0] q [4]);
    logic ak;
    bus_start(); send_byte(8'hA0, ak); send_byte(a, ak);
    bus_start(); send_byte(8'hA1, ak);
    for (int k = 0; k < n; k++) begin
      recv_bits(q[k]); send_ack(k == n - 1);
    end
    bus_stop();
  endtask

  task automatic int_write(input logic [7:0] wa, input logic [1:0] be, input logic [15:0] v);
    int_addr = wa; int_be = be; int_wdata = v; int_we = 1'b1;
    wclk(1); int_we = 1'b0;
  endtask

  task automatic int_read(input logic [7:0] wa, output logic [15:0] v);
    int_addr = wa; wclk(2); v = int_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] q [4];
    check("R10 sda released after reset", int'(sda_oe), 0);
    bus_read(8'd127, 1, q);
    check("R10 page register reset value", int'(q[0]), 8'h00);
  endtask

  task automatic t_address();
    logic ak;
    clear_drv(); bus_start(); send_byte(8'hA0, ak);
    check("R1 A0h acknowledged", int'(ak), 1); bus_stop();
    clear_drv(); bus_start(); send_byte(8'hA2, ak);
    check("R1 foreign address not acknowledged", int'(ak), 0);
    send_byte(8'h00, ak);
    check("R1 silent after foreign address", int'(drv_seen), 0); bus_stop();
  endtask

  task automatic t_select();
    logic ak;
    sel_n = 1'b1; wclk(2); clear_drv();
    bus_start(); send_byte(8'hA0, ak);
    check("R2 no ack while deselected", int'(ak), 0);
    send_byte(8'h10, ak); bus_stop();
    check("R2 SDA never driven while deselected", int'(drv_seen), 0);
    sel_n = 1'b0; wclk(2);
  endtask

  task automatic t_lower();
    logic [7:0] d [4];
    logic [7:0] q [4];
    logic [15:0] w;
    d = '{8'h11, 8'h22, 8'h33, 8'h00};
    bus_write(8'h10, d, 3);
    int_read(8'd8, w);  check("R4 sequential write word 8", int'(w), 16'h1122);
    int_read(8'd9, w);  check("R4 sequential write word 9 hi", int'(w[15:8]), 8'h33);
    bus_read(8'h10, 3, q);
    check("R3 repeated start read byte0", int'(q[0]), 8'h11);
    check("R3 repeated start read byte1", int'(q[1]), 8'h22);
    check("R4 read auto-increment byte2", int'(q[2]), 8'h33);
    int_write(8'd9, 2'b01, 16'hFF44);
    int_read(8'd9, w);  check("R9 byte enable keeps high byte", int'(w), 16'h3344);
    bus_read(8'h13, 1, q);
    check("R9 word port write visible on bus", int'(q[0]), 8'h44);
  endtask

  task automatic t_wrap_lower();
    logic [7:0] d [4];
    logic [15:0] w;
    d = '{8'h5A, 8'h00, 8'h77, 8'h00};
    bus_write(8'd126, d, 3);
    int_read(8'd63, w); check("R4 byte 126 written", int'(w[15:8]), 8'h5A);
    int_read(8'd0, w);  check("R4 lower wrap 127 to 0", int'(w[15:8]), 8'h77);
  endtask

  task automatic t_pages();
    logic [7:0] d [4];
    logic [7:0] q [4];
    logic [15:0] w;
    wr1(8'd127, 8'h00); wr1(8'd128, 8'hAA);
    wr1(8'd127, 8'h03); wr1(8'd128, 8'hBB);
    int_read(8'd64, w);  check("R5 page 0 maps to bank 1", int'(w[15:8]), 8'hAA);
    int_read(8'd128, w); check("R5 page 3 maps to bank 2", int'(w[15:8]), 8'hBB);
    bus_read(8'd127, 1, q); check("R5 page register readback", int'(q[0]), 8'h03);
    bus_read(8'd128, 1, q); check("R5 upper read through page 3", int'(q[0]), 8'hBB);
    d = '{8'hC1, 8'hC2, 8'h00, 8'h00};
    bus_write(8'd255, d, 2);
    int_read(8'd191, w); check("R4 byte 255 written", int'(w[7:0]), 8'hC1);
    int_read(8'd128, w); check("R4 upper wrap 255 to 128", int'(w[15:8]), 8'hC2);
  endtask

  task automatic t_unimplemented();
    logic [7:0] q [4];
    logic [15:0] w;
    wr1(8'd127, 8'h01); wr1(8'd128, 8'hEE);
    bus_read(8'd128, 1, q); check("R6 unimplemented page reads 00", int'(q[0]), 8'h00);
    int_read(8'd64, w);  check("R6 bank 1 untouched", int'(w[15:8]), 8'hAA);
    int_read(8'd128, w); check("R6 bank 2 untouched", int'(w[15:8]), 8'hC2);
    int_read(8'd0, w);   check("R6 lower page untouched", int'(w[15:8]), 8'h77);
    wr1(8'd127, 8'h00);
  endtask

  task automatic coherent_pair(input logic [7:0] a, output logic [7:0] hi, output logic [7:0] lo);
    logic ak;
    int_write(a >> 1, 2'b11, 16'h1234);
    bus_start(); send_byte(8'hA0, ak); send_byte(a, ak);
    bus_start(); send_byte(8'hA1, ak);
    recv_bits(hi);
    int_write(a >> 1, 2'b11, 16'h5678);
    send_ack(1'b0);
    recv_bits(lo); send_ack(1'b1);
    bus_stop();
  endtask

  task automatic t_coherent();
    logic [7:0] hi, lo;
    logic [7:0] q [4];
    coherent_pair(8'd22, hi, lo);
    check("R7 monitor high byte", int'(hi), 8'h12);
    check("R7 monitor low byte from capture", int'(lo), 8'h34);
    coherent_pair(8'd4, hi, lo);
    check("R7 plain byte read live", int'(lo), 8'h78);
    bus_read(8'd22, 2, q);
    check("R7 fresh transfer high", int'(q[0]), 8'h56);
    check("R7 fresh transfer low", int'(q[1]), 8'h78);
  endtask

  task automatic t_nack();
    logic ak;
    logic [7:0] b;
    logic [7:0] q [4];
    bus_start(); send_byte(8'hA0, ak); send_byte(8'h10, ak);
    bus_start(); send_byte(8'hA1, ak);
    recv_bits(b); send_ack(1'b1);
    clear_drv();
    recv_bits(b);
    check("R8 released after NACK", int'(b), 8'hFF);
    check("R8 no drive after NACK", int'(drv_seen), 0);
    bus_stop();
    bus_read(8'h11, 1, q);
    check("R8 recovers on next transfer", int'(q[0]), 8'h22);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wclk(5); rst = 1'b0; wclk(5);
    t_reset();
    t_address();
    t_select();
    t_lower();
    t_wrap_lower();
    t_pages();
    t_unimplemented();
    t_coherent();
    t_nack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule